// File: doc/BRIEF.md
# Staggered Multi-Domain Capture Sequencer

This block runs the capture window of an at-speed scan test when several clock domains share one scan enable and the clock skew between them is not managed. When a capture is requested, the shared scan enable drops. The domains then capture one slot at a time, in an order supplied with each test vector, so that no domain captures while a domain that drives it is changing state. Domains given the same slot index capture together. Slot indices that no domain uses are skipped.

Each domain that is not capturing is kept quiet in one of two ways, chosen per window. In suppress mode its clock enable is removed. In hold mode its clock keeps running and its hold control is raised, so its flops keep their state. A guard gap in which no domain captures comes before every slot and after the last one. The sequencer runs on the slowest domain clock. Each domain's enable and hold decisions pass through a synchronizer clocked by that domain's own clock, so the gated clocks do not glitch. Generating the clocks and moving the scan data are left to other blocks.

Top module: `stagger_capture_ctrl`

## Requirements
- R1: After reset, `scan_en` is 1, every `dom_clk_en` bit is 1 and every `dom_hold` bit is 0.
- R2: A `start` sampled high while the block is idle opens a window. `scan_en` is 0 from the next cycle for exactly GUARD*(k+1) + k*L cycles and then returns to 1. Here GUARD = SYNC_STAGES+1 (3 by default), k is the number of distinct slot indices in use and L is the effective slot length.
- R3: The slot index of domain d is `order[2d+1:2d]`. Used slots run in ascending index order. All domains that share an index capture in the same slot, and unused indices take no time.
- R4: When `hold_mode` is 0 (suppress), only the domains of the current slot have their clock enabled during a window, `dom_hold` stays 0, and in gaps no domain clock is enabled.
- R5: When `hold_mode` is 1 (hold), every clock enable stays 1 during a window. `dom_hold` is 1 for every domain outside the current slot, and for all domains during gaps.
- R6: Every slot lasts `slot_len` controller cycles. A `slot_len` of 0 is treated as 1.
- R7: A gap of GUARD cycles in which no domain captures precedes every slot and follows the last slot.
- R8: `order`, `hold_mode` and `slot_len` are latched when a window opens. Later changes to them, and `start` pulses during the window, have no effect on that window.
- R9: The per-domain outputs follow the controller's decision with a delay of SYNC_STAGES edges of that domain's clock. `scan_en` has no such delay.
- R10: With `start` held high, the block stays idle for exactly one cycle between windows and then opens the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Sequencer clock (slowest domain clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_clk | input | NDOM | Clock of each domain |
| start | input | 1 | Request to open a capture window |
| order | input | NDOM*IDX_W | Slot index of each domain, IDX_W bits per domain |
| hold_mode | input | 1 | 0 = suppress idle clocks, 1 = hold idle domains |
| slot_len | input | LEN_W | Slot length in controller cycles (0 treated as 1) |
| scan_en | output | 1 | Shared scan enable (1 = shift) |
| dom_clk_en | output | NDOM | Clock enable of each domain |
| dom_hold | output | NDOM | Hold control of each domain |

## Verification
Two events can fall in the same cycle. One is the window closing on its final gap cycle, which coincides with a `start` that is still high. The other is a fresh `start` and a change of configuration arriving on the very edge that latches the configuration. The bench holds `start` high across the end of a window and expects one idle cycle followed by a new window. In every swept window it also raises `start` again mid-window and scrambles `order`, `hold_mode` and `slot_len` on the cycle just after the latching edge. Each window is judged cycle by cycle against a waveform computed arithmetically from the configuration that was latched.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_SLOT = 2'd2
   } seq_state_t;
endpackage

// File: rtl/scc_slot_map.sv
`timescale 1ns/1ps
module scc_slot_map #(
   parameter int NDOM  = 3,
   parameter int IDX_W = 2,
   localparam int NSLOT = 1 << IDX_W
) (
   input  logic [NDOM*IDX_W-1:0] order,
   input  logic [IDX_W-1:0]      slot,
   output logic [NSLOT-1:0]      occ,
   output logic [NDOM-1:0]       hit
);
   always_comb begin
      occ = '0;
      for (int d = 0; d < NDOM; d++) occ[order[d*IDX_W +: IDX_W]] = 1'b1;
   end

   for (genvar d = 0; d < NDOM; d++) begin : g_hit
      assign hit[d] = (order[d*IDX_W +: IDX_W] == slot);
   end
endmodule

// File: rtl/scc_dom_sync.sv
`timescale 1ns/1ps
module scc_dom_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scc_sequencer.sv
`timescale 1ns/1ps
module scc_sequencer
   import scc_pkg::*;
#(
   parameter int NDOM  = 3,
   parameter int IDX_W = 2,
   parameter int LEN_W = 4,
   parameter int GUARD = 3,
   localparam int NSLOT = 1 << IDX_W,
   localparam int GW    = $clog2(GUARD + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [NDOM*IDX_W-1:0] order,
   input  logic                  hold_mode,
   input  logic [LEN_W-1:0]      slot_len,
   output logic                  scan_en_o,
   output logic [NDOM-1:0]       en_c,
   output logic [NDOM-1:0]       hold_c
);
   seq_state_t            st_q;
   logic [NDOM*IDX_W-1:0] order_q;
   logic                  mode_q;
   logic [LEN_W-1:0]      len_q;
   logic [NSLOT-1:0]      pend_q;
   logic [IDX_W-1:0]      slot_q;
   logic [GW-1:0]         gcnt_q;
   logic [LEN_W-1:0]      lcnt_q;

   logic [NSLOT-1:0]      occ_in;
   logic [NSLOT-1:0]      occ_unused;
   logic [NDOM-1:0]       hit_unused;
   logic [NDOM-1:0]       hit;
   logic [NDOM-1:0]       cap;
   logic [IDX_W-1:0]      low_idx;

   // occupancy of the incoming order, captured when a window opens
   scc_slot_map #(.NDOM(NDOM), .IDX_W(IDX_W)) u_map_in (
      .order(order), .slot(slot_q), .occ(occ_in), .hit(hit_unused));

   // which latched domains belong to the running slot
   scc_slot_map #(.NDOM(NDOM), .IDX_W(IDX_W)) u_map_run (
      .order(order_q), .slot(slot_q), .occ(occ_unused), .hit(hit));

   always_comb begin
      low_idx = '0;
      for (int s = NSLOT - 1; s >= 0; s--)
         if (pend_q[s]) low_idx = IDX_W'(s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         order_q <= '0;
         mode_q  <= 1'b0;
         len_q   <= LEN_W'(1);
         pend_q  <= '0;
         slot_q  <= '0;
         gcnt_q  <= '0;
         lcnt_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               order_q <= order;
               mode_q  <= hold_mode;
               len_q   <= (slot_len == '0) ? LEN_W'(1) : slot_len;
               pend_q  <= occ_in;
               gcnt_q  <= '0;
               st_q    <= ST_GAP;
            end
            ST_GAP: if (gcnt_q == GW'(GUARD - 1)) begin
               if (|pend_q) begin
                  slot_q          <= low_idx;
                  pend_q[low_idx] <= 1'b0;
                  lcnt_q          <= '0;
                  st_q            <= ST_SLOT;
               end else begin
                  st_q <= ST_IDLE;
               end
            end else begin
               gcnt_q <= gcnt_q + GW'(1);
            end
            ST_SLOT: if (lcnt_q == len_q - LEN_W'(1)) begin
               gcnt_q <= '0;
               st_q   <= ST_GAP;
            end else begin
               lcnt_q <= lcnt_q + LEN_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign scan_en_o = (st_q == ST_IDLE);
   assign cap       = (st_q == ST_SLOT) ? hit : '0;

   always_comb begin
      if (st_q == ST_IDLE) begin
         en_c   = '1;
         hold_c = '0;
      end else begin
         en_c   = cap | {NDOM{mode_q}};
         hold_c = mode_q ? ~cap : '0;
      end
   end

   AST_GAP_BEFORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (cap != '0 && cap != $past(cap)) |-> ($past(cap) == '0)); // R7
   AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_en_o) |-> ($past(cap) == '0)); // R7
   AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en_o && !$past(scan_en_o)) |->
      ($stable(order_q) && $stable(mode_q) && $stable(len_q))); // R8
   AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLOT && $past(st_q) == ST_SLOT) |-> $stable(cap)); // R6
   AST_HOLD_CLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_c != '0) |-> (&en_c)); // R5
endmodule

// File: rtl/stagger_capture_ctrl.sv
`timescale 1ns/1ps
module stagger_capture_ctrl #(
   parameter int NDOM        = 3,
   parameter int IDX_W       = 2,
   parameter int LEN_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int GUARD      = SYNC_STAGES + 1
) (
   input  logic                  clk_ctl,
   input  logic                  rst_n,
   input  logic [NDOM-1:0]       dom_clk,
   input  logic                  start,
   input  logic [NDOM*IDX_W-1:0] order,
   input  logic                  hold_mode,
   input  logic [LEN_W-1:0]      slot_len,
   output logic                  scan_en,
   output logic [NDOM-1:0]       dom_clk_en,
   output logic [NDOM-1:0]       dom_hold
);
   if (NDOM < 1 || IDX_W < 1 || LEN_W < 1 || SYNC_STAGES < 2) begin : g_param_bad
      $error("stagger_capture_ctrl: parameter out of range");
   end

   logic [NDOM-1:0] en_c;
   logic [NDOM-1:0] hold_c;

   scc_sequencer #(
      .NDOM(NDOM), .IDX_W(IDX_W), .LEN_W(LEN_W), .GUARD(GUARD)
   ) u_seq (
      .clk(clk_ctl), .rst_n(rst_n), .start(start), .order(order),
      .hold_mode(hold_mode), .slot_len(slot_len),
      .scan_en_o(scan_en), .en_c(en_c), .hold_c(hold_c));

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      scc_dom_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en (
         .clk(dom_clk[d]), .rst_n(rst_n), .d(en_c[d]), .q(dom_clk_en[d]));
      scc_dom_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hold (
         .clk(dom_clk[d]), .rst_n(rst_n), .d(hold_c[d]), .q(dom_hold[d]));
   end
endmodule

// File: tb/stagger_capture_ctrl_test.sv
`timescale 1ns/1ps
module stagger_capture_ctrl_test;
   localparam int GUARD = 3;
   localparam int SYNC  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [5:0] order = '0;
   logic       hold_mode = 1'b0;
   logic [3:0] slot_len = 4'd1;
   logic       scan_en;
   logic [2:0] dom_clk_en;
   logic [2:0] dom_hold;
   int         total = 0;
   int         fails = 0;

   always #4 clk = ~clk;

   stagger_capture_ctrl uut (
      .clk_ctl(clk), .rst_n(rst_n), .dom_clk({3{clk}}), .start(start),
      .order(order), .hold_mode(hold_mode), .slot_len(slot_len),
      .scan_en(scan_en), .dom_clk_en(dom_clk_en), .dom_hold(dom_hold));

   task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // expected {scan_en, clk_en[2:0], hold[2:0]} t cycles after the opening edge
   function automatic logic [6:0] model(logic [5:0] o, logic m, int L, int t);
      int pos;
      logic [2:0] cap;
      logic [6:0] gap;
      gap = {1'b0, {3{m}}, {3{m}}};
      if (t < 0) return 7'b1_111_000;
      if (t < GUARD) return gap;
      pos = GUARD;
      for (int s = 0; s < 4; s++) begin
         cap = 3'b000;
         for (int d = 0; d < 3; d++) if (o[2*d +: 2] == 2'(s)) cap[d] = 1'b1;
         if (cap != 3'b000) begin
            if (t < pos + L) return {1'b0, cap | {3{m}}, m ? ~cap : 3'b000};
            pos += L;
            if (t < pos + GUARD) return gap;
            pos += GUARD;
         end
      end
      return 7'b1_111_000;
   endfunction

   function automatic int window_len(logic [5:0] o, int L);
      int k = 0;
      for (int s = 0; s < 4; s++)
         if (o[1:0] == 2'(s) || o[3:2] == 2'(s) || o[5:4] == 2'(s)) k++;
      return GUARD * (k + 1) + k * L;
   endfunction

   task automatic run_case(logic [5:0] o, logic m, logic [3:0] li);
      int L;
      int T;
      logic [6:0] e_c;
      logic [6:0] e_d;
      L = (li == 4'd0) ? 1 : int'(li);
      T = window_len(o, L);
      @(negedge clk);
      order = o; hold_mode = m; slot_len = li; start = 1'b1;
      for (int t = 0; t <= T + SYNC; t++) begin
         @(negedge clk);
         if (t == 0) begin // R8: scramble config and drop start after latching
            start = 1'b0; order = ~o; hold_mode = ~m; slot_len = li + 4'd5;
         end
         if (t == 3) start = 1'b1; // R8: mid-window start must be ignored
         if (t == 4) start = 1'b0;
         e_c = model(o, m, L, t);
         e_d = model(o, m, L, t - SYNC);
         chk("R2 R6 R8 scan_en", {3'b000, scan_en}, {3'b000, e_c[6]});
         chk("R3 R4 R7 R9 dom_clk_en", {1'b0, dom_clk_en}, {1'b0, e_d[5:3]});
         chk("R3 R5 R7 R9 dom_hold", {1'b0, dom_hold}, {1'b0, e_d[2:0]});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int T;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 scan_en", {3'b000, scan_en}, 4'b0001);
      chk("R1 dom_clk_en", {1'b0, dom_clk_en}, 4'b0111);
      chk("R1 dom_hold", {1'b0, dom_hold}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", {scan_en, dom_clk_en}, 4'b1111);

      // sweep every order, both modes, slot lengths 0 (=1), 1, 3 (R6)
      for (int o = 0; o < 64; o++)
         for (int m = 0; m < 2; m++)
            for (int li = 0; li < 3; li++)
               run_case(6'(o), 1'(m), (li == 2) ? 4'd3 : 4'(li));

      // R10: start held high -> one idle cycle, then the next window
      T = window_len(6'b100100, 2);
      @(negedge clk);
      order = 6'b100100; hold_mode = 1'b0; slot_len = 4'd2; start = 1'b1;
      for (int t = 0; t <= T + 1; t++) begin
         @(negedge clk);
         if (t == T - 1) chk("R10 last gap cycle", {3'b000, scan_en}, 4'b0000);
         if (t == T)     chk("R10 single idle cycle", {3'b000, scan_en}, 4'b0001);
         if (t == T + 1) chk("R10 next window opened", {3'b000, scan_en}, 4'b0000);
      end
      start = 1'b0;
      repeat (T + SYNC + 2) @(negedge clk);
      chk("R10 R2 back to idle", {scan_en, dom_clk_en}, 4'b1111);
      chk("R10 R9 hold released", {1'b0, dom_hold}, 4'b0000);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule